// File: doc/BRIEF.md
# Double-to-Single Store Word Converter

This block turns a 64-bit double-precision register image into the 32-bit single-precision word written to memory by a store-single operation. It does not round. Values that single precision can hold as normals take a direct bit-field copy. Values a little too small for a single normal are denormalized by a shift loop that runs one position per cycle. Values below that window give an all-zero word.

The requester raises `start` for one cycle with the operand on `op_in`. The unit answers with a one-cycle `done` pulse and the converted word on `word_out`. The direct copy and the all-zero case answer one cycle after the operand is accepted. The shift path takes one cycle for each shift step. While a shift is running, the unit ignores any new `start`.

Top module: `d2s_store_conv`

## Requirements
- R1: Let the operand exponent be `op_in[62:52]` (biased). When it is greater than 896, `word_out[31:30]` equals `op_in[63:62]` and `word_out[29:0]` equals `op_in[58:29]`.
- R2: When `op_in[62:0]` is all zero (positive or negative zero), the copy rule of R1 applies, so the word is `{op_in[63], 31'b0}`.
- R3: When the exponent is in 874..896, `word_out[31]` is `op_in[63]` and `word_out[30:23]` is zero. `word_out[22:0]` holds bits 51..29 of the 53-bit significand `{1'b1, op_in[51:0]}` after it has been shifted right by 897 minus the exponent, with zeros filling from the top.
- R4: On the shift path, `done` rises exactly 897 minus the exponent clock cycles after the edge that accepts `start`, which is between 1 and 23 cycles.
- R5: When the exponent is below 874 and `op_in[62:0]` is not zero, the word is all zeros.
- R6: On the copy and zero paths, `done` is high for exactly the one cycle after the accepting edge. Each accepted operand produces exactly one `done` pulse.
- R7: A `start` that arrives while a shift is in progress is ignored. It produces no `done` pulse and does not change the result or the timing of the operation in flight.
- R8: Synchronous active-high `rst` abandons any operation in progress and holds `done` low and `word_out` at zero. After reset is released, the unit accepts a new `start` at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Requests a conversion of `op_in` |
| op_in | input | 64 | Double-precision register image |
| done | output | 1 | One-cycle pulse: `word_out` holds a new result |
| word_out | output | 32 | Single-precision memory word |

## Verification
The hardest situation to reach from the ports is a `start` that lands in the last cycle of a long shift, when the counter is about to expire and the unit is on the point of going idle. Getting there needs exponents near 874, which random doubles almost never produce. The stimulus therefore draws most exponents from a narrow band around 874..897 and mixes in the copy, zero and undefined classes. It leaves random gaps of zero to three cycles between requests and sometimes holds `start` high for many cycles, so that requests fall on every cycle of a shift, including its final cycle. A reset issued in the middle of a shift checks that the abandoned operation never raises `done`.

// File: rtl/d2s_pkg.sv
package d2s_pkg;
   // Which of the three conversion routes an operand takes
   typedef enum logic [1:0] {
      PATH_COPY   = 2'd0,
      PATH_DENORM = 2'd1,
      PATH_ZERO   = 2'd2
   } path_e;
endpackage

// File: rtl/d2s_classify.sv
module d2s_classify
   import d2s_pkg::*;
#(
   parameter int DW         = 64,
   parameter int OW         = 32,
   parameter int EXP_W      = 11,
   parameter int DROP       = 3,
   parameter int COPY_ABOVE = 896,
   parameter int DENORM_LO  = 874,
   parameter int CNT_W      = 5
) (
   input  logic [DW-1:0]    op,
   output path_e            path,
   output logic [CNT_W-1:0] steps,
   output logic [OW-1:0]    copy_word
);
   localparam logic [EXP_W-1:0] COPY_ABOVE_V = EXP_W'(COPY_ABOVE);
   localparam logic [EXP_W-1:0] DENORM_LO_V  = EXP_W'(DENORM_LO);
   localparam logic [CNT_W-1:0] STEP_BASE    = CNT_W'(COPY_ABOVE + 1);

   logic [EXP_W-1:0] bexp;
   logic             mag_zero;

   assign bexp     = op[DW-2 -: EXP_W];
   assign mag_zero = (op[DW-2:0] == '0);

   // copy route keeps sign and exponent MSB, skips DROP exponent bits
   assign copy_word = {op[DW-1 -: 2], op[DW-3-DROP -: OW-2]};

   // result is below 32 for every exponent in the window, so the
   // truncated subtraction is exact there
   assign steps = STEP_BASE - bexp[CNT_W-1:0];

   always_comb begin
      if (bexp > COPY_ABOVE_V || mag_zero)
         path = PATH_COPY;
      else if (bexp >= DENORM_LO_V)
         path = PATH_DENORM;
      else
         path = PATH_ZERO;
   end
endmodule

// File: rtl/d2s_denorm_shift.sv
module d2s_denorm_shift #(
   parameter int SIG_W      = 53,
   parameter int OUT_FRAC_W = 23,
   parameter int MAX_STEPS  = 23,
   parameter int CNT_W      = 5
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  load,
   input  logic                  sign_in,
   input  logic [SIG_W-1:0]      sig_in,
   input  logic [CNT_W-1:0]      steps_in,
   output logic                  busy,
   output logic                  last,
   output logic                  sign_out,
   output logic [OUT_FRAC_W-1:0] frac_out
);
   logic [SIG_W-1:0] sig_q;
   logic [CNT_W-1:0] cnt_q;
   logic             sign_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q  <= '0;
         sig_q  <= '0;
         sign_q <= 1'b0;
      end else if (load) begin
         cnt_q  <= steps_in;
         sig_q  <= sig_in;
         sign_q <= sign_in;
      end else if (busy) begin
         cnt_q <= cnt_q - 1'b1;
         sig_q <= sig_q >> 1;
      end
   end

   assign busy     = (cnt_q != '0);
   assign last     = (cnt_q == CNT_W'(1));
   assign sign_out = sign_q;
   // field of the significand as it will be after the final shift
   assign frac_out = sig_q[SIG_W-1 -: OUT_FRAC_W];

   // R4: a loaded step count lies inside the window
   a_r4_load_range: assert property (@(posedge clk) disable iff (rst)
      load |-> (steps_in != '0) && (steps_in <= CNT_W'(MAX_STEPS)));

   // R7: a running count only decrements, no reload while busy
   a_r7_steady_count: assert property (@(posedge clk) disable iff (rst)
      (busy && !last) |=> busy && (cnt_q == $past(cnt_q) - 1'b1));

   a_r4_last_ends: assert property (@(posedge clk) disable iff (rst)
      (last && !load) |=> !busy);
endmodule

// File: rtl/d2s_store_conv.sv
module d2s_store_conv
   import d2s_pkg::*;
#(
   parameter int DW        = 64,
   parameter int OW        = 32,
   parameter int EXP_W     = 11,
   parameter int OUT_EXP_W = 8
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          start,
   input  logic [DW-1:0] op_in,
   output logic          done,
   output logic [OW-1:0] word_out
);
   localparam int FRAC_W     = DW - 1 - EXP_W;
   localparam int OUT_FRAC_W = OW - 1 - OUT_EXP_W;
   localparam int SIG_W      = FRAC_W + 1;
   localparam int DROP       = EXP_W - OUT_EXP_W;
   localparam int BIAS_IN    = (1 << (EXP_W - 1)) - 1;
   localparam int BIAS_OUT   = (1 << (OUT_EXP_W - 1)) - 1;
   localparam int COPY_ABOVE = BIAS_IN - BIAS_OUT;
   localparam int MAX_STEPS  = OUT_FRAC_W;
   localparam int DENORM_LO  = COPY_ABOVE - MAX_STEPS + 1;
   localparam int CNT_W      = $clog2(MAX_STEPS + 1);

   generate
      if (OUT_EXP_W >= EXP_W) begin : g_bad_exp
         $error("output exponent must be narrower than input exponent");
      end
      if (OUT_FRAC_W > FRAC_W) begin : g_bad_frac
         $error("output fraction wider than input fraction");
      end
      if (DW - DROP - OW < 0) begin : g_bad_copy
         $error("copy field does not fit in the operand");
      end
      if (COPY_ABOVE + 1 >= (1 << CNT_W) * 64) begin : g_bad_cnt
         $error("step counter too narrow");
      end
   endgenerate

   path_e                 path;
   logic [CNT_W-1:0]      steps;
   logic [OW-1:0]         copy_word;
   logic                  busy, last, sh_sign, accept, load;
   logic [OUT_FRAC_W-1:0] sh_frac;

   d2s_classify #(
      .DW(DW), .OW(OW), .EXP_W(EXP_W), .DROP(DROP),
      .COPY_ABOVE(COPY_ABOVE), .DENORM_LO(DENORM_LO), .CNT_W(CNT_W)
   ) u_classify (
      .op(op_in), .path(path), .steps(steps), .copy_word(copy_word)
   );

   assign accept = start && !busy;
   assign load   = accept && (path == PATH_DENORM);

   d2s_denorm_shift #(
      .SIG_W(SIG_W), .OUT_FRAC_W(OUT_FRAC_W),
      .MAX_STEPS(MAX_STEPS), .CNT_W(CNT_W)
   ) u_shift (
      .clk(clk), .rst(rst), .load(load),
      .sign_in(op_in[DW-1]), .sig_in({1'b1, op_in[FRAC_W-1:0]}),
      .steps_in(steps), .busy(busy), .last(last),
      .sign_out(sh_sign), .frac_out(sh_frac)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         done     <= 1'b0;
         word_out <= '0;
      end else begin
         done <= 1'b0;
         if (last) begin
            done     <= 1'b1;
            word_out <= {sh_sign, {OUT_EXP_W{1'b0}}, sh_frac};
         end else if (accept && path != PATH_DENORM) begin
            done     <= 1'b1;
            word_out <= (path == PATH_COPY) ? copy_word : '0;
         end
      end
   end

   // R1: copy route carries the top two operand bits through
   a_r1_copy_top: assert property (@(posedge clk) disable iff (rst)
      (accept && path == PATH_COPY) |=>
         done && (word_out[OW-1 -: 2] == $past(op_in[DW-1 -: 2])));

   // R5: undefined range yields zero word
   a_r5_undef_zero: assert property (@(posedge clk) disable iff (rst)
      (accept && path == PATH_ZERO) |=> done && (word_out == '0));

   // R3: shift result has cleared exponent field
   a_r3_denorm_field: assert property (@(posedge clk) disable iff (rst)
      last |=> done && (word_out[OW-2 -: OUT_EXP_W] == '0));

   // R6: every done pulse comes from an accept or a finishing shift
   a_r6_done_origin: assert property (@(posedge clk) disable iff (rst)
      done |-> ($past(accept) && $past(path) != PATH_DENORM) || $past(last));

   // R7: a request during a shift produces no pulse next cycle
   a_r7_busy_quiet: assert property (@(posedge clk) disable iff (rst)
      (busy && !last) |=> !done);
endmodule

// File: tb/d2s_store_conv_tb.sv
`timescale 1ns/1ps
module d2s_store_conv_tb;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        start = 1'b0;
   logic [63:0] op_in = '0;
   logic        done;
   logic [31:0] word_out;

   int errors = 0;
   int checks = 0;
   int cyc = 0;
   bit finished = 1'b0;
   bit run = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   d2s_store_conv u_dut (
      .clk(clk), .rst(rst), .start(start), .op_in(op_in),
      .done(done), .word_out(word_out)
   );

   // ---------------- reference model ----------------
   int          m_cnt = 0;
   bit          m_done = 1'b0;
   logic [31:0] m_word = '0;
   logic [31:0] m_pend = '0;
   string       m_tag = "R6";
   string       p_tag = "R3";

   function automatic logic [31:0] ref_word(input logic [63:0] d);
      int e;
      logic [52:0] s;
      e = int'(d[62:52]);
      if (e > 896 || d[62:0] == 63'd0)          // R1 / R2
         return {d[63:62], d[58:29]};
      if (e >= 874) begin                       // R3
         s = {1'b1, d[51:0]};
         s = s >> (897 - e);
         return {d[63], 8'd0, s[51:29]};
      end
      return 32'd0;                             // R5
   endfunction

   function automatic string ref_tag(input logic [63:0] d);
      int e;
      e = int'(d[62:52]);
      if (d[62:0] == 63'd0) return "R2";
      if (e > 896) return "R1";
      if (e >= 874) return "R3";
      return "R5";
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         m_cnt  = 0;
         m_done = 1'b0;
         m_word = '0;
      end else begin
         m_done = 1'b0;
         if (m_cnt > 0) begin
            // R7: start seen here is ignored
            m_cnt--;
            if (m_cnt == 0) begin
               m_done = 1'b1;
               m_word = m_pend;
               m_tag  = p_tag;
            end
         end else if (start) begin
            if (ref_tag(op_in) == "R3") begin
               m_cnt  = 897 - int'(op_in[62:52]);   // R4
               m_pend = ref_word(op_in);
               p_tag  = "R3";
            end else begin
               m_done = 1'b1;                      // R6
               m_word = ref_word(op_in);
               m_tag  = ref_tag(op_in);
            end
         end
      end
   end

   // ---------------- per-cycle comparison ----------------
   always @(negedge clk) begin
      if (run && !finished) begin
         checks++;
         if (done !== m_done) begin
            errors++;
            $display("FAIL R4/R6/R7/R8 done: actual=%b expected=%b (cycle %0d)",
                     done, m_done, cyc);
         end
         if (m_done) begin
            checks++;
            if (word_out !== m_word) begin
               errors++;
               $display("FAIL %s word_out: actual=%h expected=%h (cycle %0d)",
                        m_tag, word_out, m_word, cyc);
            end
         end
      end
   end

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !finished) begin
         errors++;
         $display("FAIL watchdog: actual=hung expected=finished");
         summary();
      end
   end

   task automatic drive(input logic s, input logic [63:0] d);
      @(negedge clk);
      start = s;
      op_in = d;
   endtask

   task automatic op(input logic [63:0] d, input int gap);
      drive(1'b1, d);
      for (int i = 0; i < gap; i++) drive(1'b0, 64'd0);
   endtask

   function automatic logic [63:0] rand_op();
      int k;
      logic [63:0] d;
      k = $urandom_range(0, 9);
      d = {$urandom(), $urandom()};
      if (k < 6)       d[62:52] = 11'(870 + $urandom_range(0, 30));
      else if (k == 6) d[62:0]  = 63'd0;
      else if (k == 7) d[62:52] = 11'($urandom_range(0, 873));
      return d;
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      // R8: reset state
      checks++;
      if (done !== 1'b0 || word_out !== 32'd0) begin
         errors++;
         $display("FAIL R8 reset: actual=%b/%h expected=0/00000000", done, word_out);
      end
      rst = 1'b0;
      run = 1'b1;

      op(64'h3FF0_0000_0000_0000, 2);   // R1 1.0
      op(64'hC009_21FB_5444_2D18, 2);   // R1 negative
      op(64'h7FF0_0000_0000_0000, 2);   // R1 infinity
      op(64'h7FF8_0000_0000_0001, 2);   // R1 NaN
      op(64'h3810_0000_0000_0000, 2);   // R1 exponent 897
      op(64'h8000_0000_0000_0000, 2);   // R2 negative zero
      op(64'h0000_0000_0000_0000, 2);   // R2 positive zero
      op(64'h3800_0000_0000_0000, 3);   // R3/R4 one step
      op(64'hB6A0_0000_0000_0000, 25);  // R3/R4 23 steps, negative
      op(64'h3750_0000_2000_0000, 15);  // R3 mid window
      op(64'h3690_0000_0000_0000, 2);   // R5 exponent 873
      op(64'h0000_0000_0000_0001, 2);   // R5 tiny value
      op(64'h8010_0000_0000_0000, 2);   // R5 negative small

      // R7: requests hammering a long shift
      drive(1'b1, 64'h36A0_0000_0000_0000);
      for (int i = 0; i < 30; i++) drive(1'b1, 64'h3FF0_0000_0000_0000);
      drive(1'b0, 64'd0);
      repeat (3) drive(1'b0, 64'd0);

      // R8: reset during a shift
      op(64'h36B0_0000_0000_0000, 5);
      @(negedge clk); rst = 1'b1;
      @(negedge clk); rst = 1'b0;
      repeat (25) drive(1'b0, 64'd0);
      op(64'h3FF8_0000_0000_0000, 2);   // accepted right after reset

      // mixed random traffic
      for (int n = 0; n < 400; n++) begin
         if ($urandom_range(0, 7) == 0) begin
            for (int j = 0; j < 20; j++) drive(1'b1, rand_op());
         end else begin
            op(rand_op(), $urandom_range(0, 3));
         end
      end
      repeat (30) drive(1'b0, 64'd0);
      summary();
   end
endmodule